// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block produces the reset strobe that goes out to the board when a watchdog expires. A single-cycle request starts a pulse. The pulse lasts a programmable number of microsecond ticks, supplied as a one-cycle tick input. The pulse level follows a selectable polarity. An output-enable lets a push-pull pad behave like an open-drain driver. A request that arrives during a pulse starts the duration count again.

All settings sit in one 32-bit register. The duration field in the low bits is replaced by every write. The polarity bit and the drive-mode bit change only when the written top byte matches one of four key values. Any other top byte leaves both bits as they were. A stray or partial write therefore cannot flip how the pulse appears on the board.

Top module: `ext_reset_pulser`

## Requirements
- R1: After reset the register reads 0x000000FF: active-low polarity (bit 31 = 0), open-drain drive (bit 30 = 0), and width 0xFF. The output sits at its inactive level (high), the output-enable is low and the pulse is not active.
- R2: Every write loads bits WIDTH_BITS-1:0 of the written data into the width field, whatever the top byte holds. Bits 29 down to WIDTH_BITS always read as zero.
- R3: A write whose bits 31:24 equal 0xA5 sets the polarity bit to 1 (active-high). A write whose bits 31:24 equal 0x5A clears it to 0 (active-low). The new value reads back on bit 31 the cycle after the write.
- R4: A write whose bits 31:24 equal 0xA8 sets the drive bit to 1 (push-pull). A write whose bits 31:24 equal 0x8A clears it to 0 (open-drain). The new value reads back on bit 30.
- R5: A write with any other top-byte value leaves both the polarity bit and the drive bit unchanged.
- R6: pulseActive rises on the clock edge that samples trigger high. With width N, it stays high until N+1 ticks have been consumed while active, then falls on the edge that consumes the last tick. A tick that arrives in the same cycle as a trigger is not counted.
- R7: A trigger that arrives while a pulse is active reloads the count, so N+1 further ticks follow it.
- R8: While active, pulseOut equals the polarity bit. While idle, pulseOut equals its inverse.
- R9: In push-pull mode pulseOe is always high. In open-drain mode pulseOe is high only while the pulse is active.
- R10: The width is captured when the pulse is triggered. A width write during a pulse does not change the length of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read value |
| tickIn | input | 1 | One-cycle microsecond tick |
| trigger | input | 1 | One-cycle pulse request |
| pulseOut | output | 1 | Reset pulse level |
| pulseOe | output | 1 | Pad output-enable |
| pulseActive | output | 1 | High while a pulse runs |

## Verification
A register write shows up on rdData one clock after the edge that samples it. A trigger raises pulseActive on that same one-edge delay. The bench drives every input just after a falling edge and reads the outputs at the next falling edge, so each result is observed exactly one register stage after its cause.

Pulse length is measured in consumed ticks rather than in clock cycles. Each tick the bench applies while it observes pulseActive high is counted. A tick applied in the same cycle as a trigger is not counted. The total is then compared with N+1. The top-byte sweep writes all 256 values and compares each readback with a model that holds the two mode bits.

// File: rtl/erp_pkg.sv
package erp_pkg;
  // command strobes handed from control to datapath
  typedef struct packed {
    logic load;   // start or restart the pulse with the current width
    logic step;   // consume one microsecond tick
  } pulseCmd_t;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef enum logic [2:0] {
    KEY_NONE,
    KEY_SET_HIGH,
    KEY_SET_LOW,
    KEY_SET_PP,
    KEY_SET_OD
  } keyKind_t;

  function automatic keyKind_t decodeKey(input logic [7:0] topByte);
    case (topByte)
      KEY_POL_HIGH: decodeKey = KEY_SET_HIGH;
      KEY_POL_LOW:  decodeKey = KEY_SET_LOW;
      KEY_DRV_PP:   decodeKey = KEY_SET_PP;
      KEY_DRV_OD:   decodeKey = KEY_SET_OD;
      default:      decodeKey = KEY_NONE;
    endcase
  endfunction
endpackage

// File: rtl/erp_ctrl.sv
module erp_ctrl
  import erp_pkg::*;
#(
  parameter int WIDTH_BITS = 20,
  parameter logic [WIDTH_BITS-1:0] RESET_WIDTH = WIDTH_BITS'(8'hFF)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [31:0]           wrData,
  input  logic                  trigger,
  input  logic                  tickIn,
  output pulseCmd_t             cmd,
  output logic [WIDTH_BITS-1:0] widthVal,
  output logic                  activeHigh,
  output logic                  pushPull,
  output logic [31:0]           rdData
);
  localparam int PAD_BITS = 30 - WIDTH_BITS;

  keyKind_t keyKind;
  logic [WIDTH_BITS-1:0] widthQ;
  logic activeHighQ;
  logic pushPullQ;

  always_comb keyKind = decodeKey(wrData[31:24]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthQ      <= RESET_WIDTH;
      activeHighQ <= 1'b0;
      pushPullQ   <= 1'b0;
    end else if (wrEn) begin
      widthQ <= wrData[WIDTH_BITS-1:0];
      case (keyKind)
        KEY_SET_HIGH: activeHighQ <= 1'b1;
        KEY_SET_LOW:  activeHighQ <= 1'b0;
        KEY_SET_PP:   pushPullQ   <= 1'b1;
        KEY_SET_OD:   pushPullQ   <= 1'b0;
        default: ;
      endcase
    end
  end

  // trigger wins over a coincident tick
  always_comb begin
    cmd.load = trigger;
    cmd.step = tickIn & ~trigger;
  end

  assign widthVal   = widthQ;
  assign activeHigh = activeHighQ;
  assign pushPull   = pushPullQ;

  generate
    if (PAD_BITS > 0) begin : g_pad
      assign rdData = {activeHighQ, pushPullQ, {PAD_BITS{1'b0}}, widthQ};
    end else begin : g_nopad
      assign rdData = {activeHighQ, pushPullQ, widthQ};
    end
  endgenerate

  p_width_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> widthVal == $past(wrData[WIDTH_BITS-1:0]));
  p_pol_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[31:24] == 8'hA5 |=> rdData[31]);
  p_pol_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[31:24] == 8'h5A |=> !rdData[31]);
  p_drv_pp_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[31:24] == 8'hA8 |=> rdData[30]);
  p_drv_od_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[31:24] == 8'h8A |=> !rdData[30]);
  p_mode_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[31:24] != 8'hA5 && wrData[31:24] != 8'h5A &&
    wrData[31:24] != 8'hA8 && wrData[31:24] != 8'h8A
    |=> $stable(rdData[31:30]));
endmodule

// File: rtl/erp_datapath.sv
module erp_datapath
  import erp_pkg::*;
#(
  parameter int WIDTH_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pulseCmd_t             cmd,
  input  logic [WIDTH_BITS-1:0] widthVal,
  input  logic                  activeHigh,
  input  logic                  pushPull,
  output logic                  pulseActive,
  output logic                  pulseOut,
  output logic                  pulseOe
);
  logic [WIDTH_BITS-1:0] countQ;
  logic [WIDTH_BITS-1:0] latchQ;
  logic activeQ;
  logic lastTick;

  assign lastTick = (countQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      countQ  <= '0;
      latchQ  <= '0;
    end else if (cmd.load) begin
      activeQ <= 1'b1;
      countQ  <= widthVal;
      latchQ  <= widthVal;
    end else if (cmd.step && activeQ) begin
      if (lastTick) activeQ <= 1'b0;
      else          countQ  <= countQ - 1'b1;
    end
  end

  assign pulseActive = activeQ;
  assign pulseOut    = activeQ ^ ~activeHigh;
  assign pulseOe     = pushPull | activeQ;

  p_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> pulseActive && countQ == $past(widthVal));
  p_end_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseActive) |-> $past(cmd.step) && $past(countQ) == '0);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && !cmd.load && !cmd.step |=> pulseActive && $stable(countQ));
  p_count_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |-> countQ <= latchQ);
endmodule

// File: rtl/ext_reset_pulser.sv
module ext_reset_pulser
  import erp_pkg::*;
#(
  parameter int WIDTH_BITS = 20,
  parameter logic [WIDTH_BITS-1:0] RESET_WIDTH = WIDTH_BITS'(8'hFF)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        tickIn,
  input  logic        trigger,
  output logic        pulseOut,
  output logic        pulseOe,
  output logic        pulseActive
);
  pulseCmd_t cmd;
  logic [WIDTH_BITS-1:0] widthVal;
  logic activeHigh;
  logic pushPull;

  erp_ctrl #(.WIDTH_BITS(WIDTH_BITS), .RESET_WIDTH(RESET_WIDTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .trigger(trigger), .tickIn(tickIn), .cmd(cmd), .widthVal(widthVal),
    .activeHigh(activeHigh), .pushPull(pushPull), .rdData(rdData)
  );

  erp_datapath #(.WIDTH_BITS(WIDTH_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .widthVal(widthVal),
    .activeHigh(activeHigh), .pushPull(pushPull),
    .pulseActive(pulseActive), .pulseOut(pulseOut), .pulseOe(pulseOe)
  );

  p_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive |-> pulseOut == rdData[31]);
  p_od_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pulseActive && !rdData[30] |-> !pulseOe);
  p_pp_oe_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdData[30] |-> pulseOe);
endmodule

// File: tb/ext_reset_pulser_tb_top.sv
module ext_reset_pulser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 8;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic tickIn = 1'b0;
  logic trigger = 1'b0;
  logic [31:0] rdData;
  logic pulseOut, pulseOe, pulseActive;

  int tests = 0;
  int fails = 0;
  int phase = 0;
  int ticksSeen = 0;
  logic sActive, sOut, sOe;
  logic ahE = 1'b0;
  logic ppE = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_reset_pulser #(.WIDTH_BITS(WB), .RESET_WIDTH(8'hFF)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .tickIn(tickIn), .trigger(trigger), .pulseOut(pulseOut),
    .pulseOe(pulseOe), .pulseActive(pulseActive)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: sample outputs, then drive inputs for the next rising edge
  task automatic cyc(input logic trig, input logic we, input logic [31:0] wd);
    @(negedge clk);
    sActive = pulseActive;
    sOut = pulseOut;
    sOe = pulseOe;
    tickIn = (phase == 0);
    phase = (phase + 1) % TICK_DIV;
    trigger = trig;
    wrEn = we;
    wrData = wd;
    if (sActive && tickIn && !trig) ticksSeen++;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 32'h0);
  endtask

  task automatic writeReg(input logic [31:0] wd);
    cyc(1'b0, 1'b1, wd);
    idle();
  endtask

  task automatic runToEnd(input string req);
    int guard = 0;
    while (sActive && guard < 5000) begin
      chk(sOut == ahE, "R8 active level", sOut, ahE);
      chk(sOe == 1'b1, "R9 oe while active", sOe, 1);
      idle();
      guard++;
    end
  endtask

  task automatic runPulse(input int n, input string req);
    cyc(1'b1, 1'b0, 32'h0);
    ticksSeen = 0;
    idle();
    chk(sActive == 1'b1, "R6 rise after trigger", sActive, 1);
    runToEnd(req);
    chk(ticksSeen == n + 1, req, ticksSeen, n + 1);
    chk(sOut == !ahE, "R8 idle level", sOut, !ahE);
    chk(sOe == ppE, "R9 oe while idle", sOe, ppE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R1 reset state
    chk(rdData == 32'h0000_00FF, "R1 reset register", rdData, 32'hFF);
    chk(sOut == 1'b1, "R1 idle output", sOut, 1);
    chk(sOe == 1'b0, "R1 oe", sOe, 0);
    chk(sActive == 1'b0, "R1 inactive", sActive, 0);

    // R2..R5 exhaustive top-byte sweep
    for (int t = 0; t < 256; t++) begin
      logic [7:0] lo;
      logic [7:0] tb8;
      tb8 = 8'(t);
      lo = tb8 ^ 8'h3C;
      case (tb8)
        8'hA5: ahE = 1'b1;
        8'h5A: ahE = 1'b0;
        8'hA8: ppE = 1'b1;
        8'h8A: ppE = 1'b0;
        default: ;
      endcase
      writeReg({tb8, 16'hFFFF, lo});
      chk(rdData == {ahE, ppE, 22'h0, lo}, "R2 R3 R4 R5 keyed write", rdData, {ahE, ppE, 22'h0, lo});
    end

    // R6 R8 R9 widths under every mode combination
    for (int m = 0; m < 4; m++) begin
      ahE = m[0];
      ppE = m[1];
      for (int n = 0; n < 8; n++) begin
        writeReg({ahE ? 8'hA5 : 8'h5A, 16'h0, 8'(n)});
        writeReg({ppE ? 8'hA8 : 8'h8A, 16'h0, 8'(n)});
        runPulse(n, "R6 tick count");
      end
    end

    // R7 retrigger mid-pulse
    writeReg({8'h00, 16'h0, 8'd3});
    cyc(1'b1, 1'b0, 32'h0);
    ticksSeen = 0;
    while (ticksSeen < 2) idle();
    cyc(1'b1, 1'b0, 32'h0);
    ticksSeen = 0;
    idle();
    chk(sActive == 1'b1, "R7 still active", sActive, 1);
    runToEnd("R7");
    chk(ticksSeen == 4, "R7 retrigger count", ticksSeen, 4);

    // R10 width write during pulse
    writeReg({8'h00, 16'h0, 8'd5});
    cyc(1'b1, 1'b0, 32'h0);
    ticksSeen = 0;
    idle();
    cyc(1'b0, 1'b1, {8'h00, 16'h0, 8'd1});
    runToEnd("R10");
    chk(ticksSeen == 6, "R10 latched width", ticksSeen, 6);
    chk(rdData[7:0] == 8'd1, "R10 new width stored", rdData[7:0], 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule